// File: doc/BRIEF.md
# Packed Single-to-Double Widening Unit

This block takes up to eight IEEE-754 binary32 values packed into a 256-bit source word and widens each one into an IEEE-754 binary64 value inside a 512-bit destination word. Every binary32 value fits exactly in binary64, so the unit has no rounding stage. Denormal inputs are normalised. Infinities keep their sign. NaN payloads are kept, and signaling NaNs are quieted. Two status conditions are reported: invalid operation, for a signaling NaN, and denormal operand.

The unit has two modes. In the extended mode, a vector-length select gives 2, 4 or 8 active lanes. An optional per-lane write mask picks, for each inactive lane, either merging (keep the old destination lane) or zeroing. A broadcast flag feeds source bits 31:0 to every lane. Destination bits above the selected length are cleared. In the legacy mode, only the low two lanes are converted, and bits 511:128 keep the old destination value. The caller supplies the old destination word alongside the operands. The result is registered on an input strobe. Status flags accumulate in sticky registers until a clear input resets them.

Top module: `widen_top`

## Requirements
- R1: During synchronous reset (`rst_n` low at a clock edge), `out_valid`, `dst`, `flag_inv` and `flag_den` all become zero.
- R2: When `in_valid` is high at a clock edge, the result is captured into `dst` and `out_valid` is high for the following cycle. When `in_valid` is low, `out_valid` goes low and `dst` holds its value.
- R3: A written lane with a normal input gets the same sign, exponent plus 896, and the 23 fraction bits followed by 29 zero bits. A zero input becomes a zero of the same sign.
- R4: A written lane with a denormal input (exponent 0, fraction nonzero) becomes the exactly equal normal binary64 value and sets `flag_den`.
- R5: Infinity becomes binary64 infinity of the same sign. A NaN becomes exponent 0x7FF with fraction bit 51 set, input fraction bits 21:0 placed at bits 50:29, and zeros below. A signaling NaN (input fraction bit 22 clear) also sets `flag_inv`.
- R6: In extended mode (`ext_mode`=1), `vlen_sel` 00 gives 2 lanes, 01 gives 4 lanes, and 10 or 11 gives 8 lanes. Destination lane j (bits 64j+63:64j) comes from source lane j (bits 32j+31:32j). Every destination bit above the active lanes becomes zero.
- R7: In legacy mode (`ext_mode`=0), lanes 0 and 1 are always converted. `dst[511:128]` takes the value of `old_dst[511:128]`. `vlen_sel`, `mask_en`, `lane_mask`, `zero_mode` and `bcast` have no effect.
- R8: In extended mode with `bcast`=1, every active lane is converted from `src[31:0]`, and the other source bits are ignored.
- R9: In extended mode, an active lane is written when `mask_en`=0 or `lane_mask[j]`=1. An active lane that is not written keeps `old_dst` lane j when `zero_mode`=0, and becomes zero when `zero_mode`=1.
- R10: Flags are collected only from written lanes and are ORed into sticky outputs. A high `flag_clr` discards the old sticky value. If `in_valid` is high in the same cycle, only the new flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe; captures a result |
| src | input | 256 | Packed binary32 source lanes |
| vlen_sel | input | 2 | Destination length select (extended mode) |
| ext_mode | input | 1 | 1: extended mode, 0: legacy mode |
| mask_en | input | 1 | Enables the per-lane write mask |
| lane_mask | input | 8 | Per-lane write enables |
| zero_mode | input | 1 | 1: unwritten lanes become zero, 0: merge |
| bcast | input | 1 | Broadcast `src[31:0]` to all lanes |
| old_dst | input | 512 | Previous destination value for merging |
| flag_clr | input | 1 | Clears the sticky flags |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| dst | output | 512 | Registered destination word |
| flag_inv | output | 1 | Sticky invalid-operation flag |
| flag_den | output | 1 | Sticky denormal-operand flag |

## Verification
The properties assume that `old_dst` and the control inputs are steady and meaningful only in cycles where `in_valid` is high. They also assume that `flag_clr` is a plain level, not tied to an operation. The stimulus drives every input one half-cycle before the sampling edge and drops `in_valid` after each operation. It uses all four `vlen_sel` codes and both modes, and it draws binary32 operands from weighted classes: zeros, denormals, infinities, quiet and signaling NaNs, and normals. This keeps the properties and the model checks on defined, reachable cases.

// File: rtl/widen_pkg.sv
// Shared constants and types for the packed single-to-double widening unit.
// Assumes binary32 in and binary64 out, with standard IEEE-754 field layouts.
package widen_pkg;
    localparam int SP_W    = 32;
    localparam int DP_W    = 64;
    localparam int SP_FRAC = 23;
    localparam int DP_FRAC = 52;
    localparam int DP_EXP  = 11;
    localparam int FRAC_PAD = DP_FRAC - SP_FRAC;          // 29 trailing zeros
    localparam logic [DP_EXP-1:0] BIAS_SHIFT = 11'd896;   // 1023 - 127

    // Length select encoding; the top code also selects the widest length.
    typedef enum logic [1:0] {
        VL_TWO   = 2'b00,
        VL_FOUR  = 2'b01,
        VL_EIGHT = 2'b10,
        VL_WIDE  = 2'b11
    } vlen_e;

    // Per-lane status produced by one converter.
    typedef struct packed {
        logic den;
        logic inv;
    } lane_stat_t;
endpackage

// File: rtl/widen_lzc.sv
// Leading-zero counter for the fraction of a denormal binary32 value.
// Assumes the input is nonzero when the count is used; an all-zero input returns W-1.
module widen_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);
    // Scan from the MSB down and take the position of the first set bit.
    always_comb begin
        logic hit;
        hit   = 1'b0;
        zeros = CW'(W - 1);
        for (int i = W - 1; i >= 0; i--) begin
            if (!hit && vec[i]) begin
                hit   = 1'b1;
                zeros = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/widen_lane.sv
// Exact binary32 to binary64 converter for one lane.
// Covers zero, denormal, normal, infinity and NaN, and raises the per-lane status bits.
module widen_lane
    import widen_pkg::*;
(
    input  logic [SP_W-1:0] sp,
    output logic [DP_W-1:0] dp,
    output lane_stat_t      stat
);
    localparam int LZ_W = $clog2(SP_FRAC);

    logic               sgn;
    logic [7:0]         ex;
    logic [SP_FRAC-1:0] fr;
    logic [LZ_W-1:0]    lz;
    logic [SP_FRAC-1:0] fr_norm;
    logic [DP_EXP-1:0]  ex_norm;

    assign sgn = sp[31];
    assign ex  = sp[30:23];
    assign fr  = sp[22:0];

    widen_lzc #(.W(SP_FRAC), .CW(LZ_W)) u_lzc (
        .vec   (fr),
        .zeros (lz)
    );

    // Normalise a denormal: drop the leading one and lower the exponent by the shift.
    always_comb begin
        fr_norm = fr << (lz + 1'b1);
        ex_norm = BIAS_SHIFT - DP_EXP'(lz);
    end

    // Choose the output encoding from the input class.
    always_comb begin
        stat = '0;
        if (ex == 8'hFF) begin
            if (fr == '0) begin
                dp = {sgn, 11'h7FF, {DP_FRAC{1'b0}}};
            end else begin
                dp       = {sgn, 11'h7FF, 1'b1, fr[SP_FRAC-2:0], {FRAC_PAD{1'b0}}};
                stat.inv = ~fr[SP_FRAC-1];
            end
        end else if (ex == 8'h00) begin
            if (fr == '0) begin
                dp = {sgn, {(DP_W-1){1'b0}}};
            end else begin
                dp       = {sgn, ex_norm, fr_norm, {FRAC_PAD{1'b0}}};
                stat.den = 1'b1;
            end
        end else begin
            dp = {sgn, DP_EXP'(ex) + BIAS_SHIFT, fr, {FRAC_PAD{1'b0}}};
        end
    end
endmodule

// File: rtl/widen_merge.sv
// Chooses the final value of one destination lane.
// Written lanes take the conversion; other lanes take zero or the old value, by mode.
module widen_merge
    import widen_pkg::*;
(
    input  logic [DP_W-1:0] conv,
    input  logic [DP_W-1:0] prev,
    input  logic            active,
    input  logic            write,
    input  logic            zero_mode,
    input  logic            clear_idle,
    output logic [DP_W-1:0] lane_out
);
    // Priority: converted value, then masked-off handling, then beyond-length handling.
    always_comb begin
        if (active && write)
            lane_out = conv;
        else if (active)
            lane_out = zero_mode ? '0 : prev;
        else
            lane_out = clear_idle ? '0 : prev;
    end
endmodule

// File: rtl/widen_top.sv
// Packed single-to-double widening unit with write mask, broadcast and length select.
// Assumes the old destination and the controls are valid whenever in_valid is high.
module widen_top
    import widen_pkg::*;
#(
    parameter int LANES = 8,
    localparam int SRC_W = LANES * SP_W,
    localparam int DST_W = LANES * DP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] src,
    input  logic [1:0]       vlen_sel,
    input  logic             ext_mode,
    input  logic             mask_en,
    input  logic [LANES-1:0] lane_mask,
    input  logic             zero_mode,
    input  logic             bcast,
    input  logic [DST_W-1:0] old_dst,
    input  logic             flag_clr,
    output logic             out_valid,
    output logic [DST_W-1:0] dst,
    output logic             flag_inv,
    output logic             flag_den
);
    localparam int CNT_W = $clog2(LANES + 1);

    logic [CNT_W-1:0] n_active;
    logic [LANES-1:0] act;
    logic [LANES-1:0] wr;
    logic [LANES-1:0] lane_inv;
    logic [LANES-1:0] lane_den;
    logic [DST_W-1:0] dst_next;
    logic             any_inv;
    logic             any_den;

    // Active lane count from the mode and the length select.
    always_comb begin
        if (!ext_mode) begin
            n_active = CNT_W'(2);
        end else begin
            unique case (vlen_e'(vlen_sel))
                VL_TWO:  n_active = CNT_W'(2);
                VL_FOUR: n_active = CNT_W'(4);
                default: n_active = CNT_W'(LANES);
            endcase
        end
    end

    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_lane
            logic [SP_W-1:0] sp_in;
            logic [DP_W-1:0] dp_out;
            lane_stat_t      st;

            // Lane source: broadcast only applies in extended mode.
            assign sp_in  = (ext_mode && bcast) ? src[SP_W-1:0] : src[j*SP_W +: SP_W];
            assign act[j] = (j < n_active);
            assign wr[j]  = act[j] && (!ext_mode || !mask_en || lane_mask[j]);

            widen_lane u_cvt (
                .sp   (sp_in),
                .dp   (dp_out),
                .stat (st)
            );

            widen_merge u_mrg (
                .conv       (dp_out),
                .prev       (old_dst[j*DP_W +: DP_W]),
                .active     (act[j]),
                .write      (wr[j]),
                .zero_mode  (ext_mode && zero_mode),
                .clear_idle (ext_mode),
                .lane_out   (dst_next[j*DP_W +: DP_W])
            );

            assign lane_inv[j] = wr[j] && st.inv;
            assign lane_den[j] = wr[j] && st.den;
        end
    endgenerate

    assign any_inv = |lane_inv;
    assign any_den = |lane_den;

    // Result register and valid pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                dst <= dst_next;
        end
    end

    // Sticky status flags: the clear drops history, a new operation ORs in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_inv <= 1'b0;
            flag_den <= 1'b0;
        end else begin
            flag_inv <= (flag_inv && !flag_clr) || (in_valid && any_inv);
            flag_den <= (flag_den && !flag_clr) || (in_valid && any_den);
        end
    end
endmodule

// File: rtl/widen_chk.sv
// Port-level properties of the widening unit, bound to every instance of the top.
// Assumes the same clock and synchronous active-low reset as the top.
module widen_chk #(
    parameter int LANES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [1:0]           vlen_sel,
    input logic                 ext_mode,
    input logic                 mask_en,
    input logic [LANES-1:0]     lane_mask,
    input logic                 zero_mode,
    input logic [LANES*64-1:0]  old_dst,
    input logic                 flag_clr,
    input logic                 out_valid,
    input logic [LANES*64-1:0]  dst,
    input logic                 flag_inv,
    input logic                 flag_den
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_dst_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dst));
    assert_clear_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ext_mode && vlen_sel == 2'b00) |=> (dst[LANES*64-1:128] == '0));
    assert_legacy_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ext_mode) |=> (dst[LANES*64-1:128] == $past(old_dst[LANES*64-1:128])));
    assert_zero_lane0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ext_mode && mask_en && zero_mode && !lane_mask[0]) |=> (dst[63:0] == '0));
    assert_merge_lane0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ext_mode && mask_en && !zero_mode && !lane_mask[0])
        |=> (dst[63:0] == $past(old_dst[63:0])));
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_valid) |=> (!flag_inv && !flag_den));
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr && flag_inv) |=> flag_inv);
    assert_den_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr && flag_den) |=> flag_den);
endmodule

bind widen_top widen_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .vlen_sel  (vlen_sel),
    .ext_mode  (ext_mode),
    .mask_en   (mask_en),
    .lane_mask (lane_mask),
    .zero_mode (zero_mode),
    .old_dst   (old_dst),
    .flag_clr  (flag_clr),
    .out_valid (out_valid),
    .dst       (dst),
    .flag_inv  (flag_inv),
    .flag_den  (flag_den)
);

// File: tb/sim_widen_top.sv
// Self-checking bench: directed corners plus seeded random operations against a bench model.
module sim_widen_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] src = '0;
    logic [1:0]   vlen_sel = '0;
    logic         ext_mode = 1'b0;
    logic         mask_en = 1'b0;
    logic [7:0]   lane_mask = '0;
    logic         zero_mode = 1'b0;
    logic         bcast = 1'b0;
    logic [511:0] old_dst = '0;
    logic         flag_clr = 1'b0;
    logic         out_valid;
    logic [511:0] dst;
    logic         flag_inv;
    logic         flag_den;

    int checks = 0;
    int errors = 0;
    logic m_inv = 1'b0;
    logic m_den = 1'b0;

    always #5 clk = ~clk;

    widen_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .vlen_sel(vlen_sel),
        .ext_mode(ext_mode), .mask_en(mask_en), .lane_mask(lane_mask), .zero_mode(zero_mode),
        .bcast(bcast), .old_dst(old_dst), .flag_clr(flag_clr), .out_valid(out_valid),
        .dst(dst), .flag_inv(flag_inv), .flag_den(flag_den)
    );

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Bench conversion by arithmetic normalisation loop.
    task automatic ref_cvt(input logic [31:0] x, output logic [63:0] y,
                           output logic den, output logic inv);
        logic [23:0] m;
        int e;
        den = 1'b0;
        inv = 1'b0;
        if (x[30:23] == 8'hFF) begin
            if (x[22:0] == '0) y = {x[31], 11'h7FF, 52'd0};
            else begin
                y   = {x[31], 11'h7FF, 1'b1, x[21:0], 29'd0};
                inv = !x[22];
            end
        end else if (x[30:23] == 8'h00) begin
            if (x[22:0] == '0) y = {x[31], 63'd0};
            else begin
                den = 1'b1;
                m = {1'b0, x[22:0]};
                e = 897;
                while (!m[23]) begin
                    m = m << 1;
                    e = e - 1;
                end
                y = {x[31], e[10:0], m[22:0], 29'd0};
            end
        end else begin
            e = int'(x[30:23]) + 896;
            y = {x[31], e[10:0], x[22:0], 29'd0};
        end
    endtask

    // Bench model of the full destination and the new flags of one operation.
    task automatic model(output logic [511:0] d, output logic fi, output logic fd);
        int n;
        logic [63:0] y;
        logic den, inv;
        n  = !ext_mode ? 2 : (vlen_sel == 2'b00 ? 2 : (vlen_sel == 2'b01 ? 4 : 8));
        fi = 1'b0;
        fd = 1'b0;
        d  = old_dst;
        for (int k = 0; k < 8; k++) begin
            if (k >= n) begin
                if (ext_mode) d[k*64 +: 64] = '0;
            end else if (!ext_mode || !mask_en || lane_mask[k]) begin
                ref_cvt((ext_mode && bcast) ? src[31:0] : src[k*32 +: 32], y, den, inv);
                d[k*64 +: 64] = y;
                fi = fi | inv;
                fd = fd | den;
            end else if (zero_mode) begin
                d[k*64 +: 64] = '0;
            end
        end
    endtask

    function automatic logic [31:0] rnd_sp();
        logic s;
        logic [22:0] f;
        s = 1'($urandom);
        f = 23'($urandom);
        case ($urandom % 7)
            0: return {s, 8'd0, 23'd0};
            1: return {s, 8'd0, (f == 0) ? 23'd5 : f};
            2: return {s, 8'hFF, 23'd0};
            3: return {s, 8'hFF, 1'b1, f[21:0]};
            4: return {s, 8'hFF, 1'b0, f[21:1], 1'b1};
            default: return {s, 8'(1 + $urandom % 254), f};
        endcase
    endfunction

    // Apply one operation at a falling edge and check at the next one.
    task automatic op(input string tag);
        logic [511:0] ed;
        logic fi, fd;
        model(ed, fi, fd);
        in_valid = 1'b1;
        m_inv = (flag_clr ? 1'b0 : m_inv) | fi;
        m_den = (flag_clr ? 1'b0 : m_den) | fd;
        @(negedge clk);
        in_valid = 1'b0;
        flag_clr = 1'b0;
        chk({tag, " R2 valid"}, {511'd0, out_valid}, 512'd1);
        chk({tag, " dst"}, dst, ed);
        chk({tag, " R10 flags"}, {510'd0, flag_inv, flag_den}, {510'd0, m_inv, m_den});
    endtask

    task automatic setup(input logic [255:0] s, input logic [1:0] vs, input logic ex,
                         input logic me, input logic [7:0] mk, input logic zm, input logic bc);
        src = s; vlen_sel = vs; ext_mode = ex; mask_en = me;
        lane_mask = mk; zero_mode = zm; bcast = bc;
        old_dst = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                   $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endtask

    initial begin
        logic [511:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset dst", dst, '0);
        chk("R1 reset valid/flags", {509'd0, out_valid, flag_inv, flag_den}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: 1.0 and negative zero, legacy mode
        setup({192'd0, 32'h8000_0000, 32'h3F80_0000}, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        op("R3 R7 legacy");
        chk("R3 one", dst[63:0], 512'h3FF0_0000_0000_0000);
        chk("R3 neg zero", dst[127:64], 512'h8000_0000_0000_0000);
        chk("R7 upper kept", dst[511:128], old_dst[511:128]);

        // R4: smallest denormal and top denormal
        setup({192'd0, 32'h0040_0000, 32'h0000_0001}, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        op("R4 denormal");
        chk("R4 min denorm", dst[63:0], 512'h36A0_0000_0000_0000);
        chk("R4 top denorm", dst[127:64], 512'h3800_0000_0000_0000);
        chk("R4 den flag", {511'd0, flag_den}, 512'd1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_inv = 1'b0; m_den = 1'b0;
        chk("R10 clear", {510'd0, flag_inv, flag_den}, '0);

        // R5: infinity, quiet NaN, signaling NaN
        setup({160'd0, 32'h7F80_0001, 32'h7FC0_0001, 32'hFF80_0000}, 2'b01, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        op("R5 specials");
        chk("R5 neg inf", dst[63:0], 512'hFFF0_0000_0000_0000);
        chk("R5 qnan", dst[127:64], 512'h7FF8_0000_2000_0000);
        chk("R5 snan quieted", dst[191:128], 512'h7FF8_0000_2000_0000);
        chk("R5 inv flag", {511'd0, flag_inv}, 512'd1);
        chk("R6 cleared above 256", dst[511:256], '0);

        // R2: hold when no strobe
        held = dst;
        src = ~src;
        @(negedge clk);
        chk("R2 hold dst", dst, held);
        chk("R2 valid low", {511'd0, out_valid}, '0);

        // R8 R9: broadcast, masked merge and zero, full width
        setup({224'hDEAD_BEEF, 32'h4049_0FDB}, 2'b10, 1'b1, 1'b1, 8'b1010_0101, 1'b0, 1'b1);
        op("R8 R9 merge bcast");
        setup({224'hDEAD_BEEF, 32'h0000_0003}, 2'b11, 1'b1, 1'b1, 8'b0101_1010, 1'b1, 1'b1);
        flag_clr = 1'b1;
        op("R8 R9 R10 zero bcast");

        // R10: masked-off snan raises nothing
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_inv = 1'b0; m_den = 1'b0;
        setup({224'd0, 32'h7F80_0001}, 2'b00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
        op("R10 masked snan");
        chk("R10 no inv", {511'd0, flag_inv}, '0);

        // R7: legacy ignores mask, zeroing and broadcast
        setup({192'd0, 32'h4000_0000, 32'h3F80_0000}, 2'b10, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
        op("R7 legacy ignores");
        chk("R7 lane1", dst[127:64], 512'h4000_0000_0000_0000);

        // R3 R6 R8 R9 R10: seeded random operations
        for (int t = 0; t < 400; t++) begin
            logic [255:0] s;
            for (int k = 0; k < 8; k++) s[k*32 +: 32] = rnd_sp();
            setup(s, 2'($urandom), ($urandom % 4) != 0, 1'($urandom), 8'($urandom),
                  1'($urandom), ($urandom % 5) == 0);
            flag_clr = ($urandom % 6) == 0;
            op("R3 R6 R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule